// File: doc/BRIEF.md
# Incremental Z-Domain PID Filter

This block is a discrete PID controller written as a recursive velocity-form difference equation. The continuous controller was mapped to the z-plane with the bilinear transform. Its proportional, integral and derivative terms then fold into three weights on the current error and the two previous errors, plus feedback of the last output. No separate P, I and D paths remain. The integrating action lives in the output feedback.

A sampling strobe at the control rate (nominally 2 kHz) marks each new signed 12-bit error sample. The host supplies three signed Q4.8 tap weights, already derived from the gains and the sample period. The block keeps the two previous error samples and the previous output. One clock after each strobe it presents a new saturated 24-bit control value together with a one-cycle valid pulse. Because the weights carry 8 fraction bits, the output carries 8 fraction bits too: it is the exact integer sum of the products, with no rounding.

Top module: `zpid_filter`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `ctl_out` is 0 and `ctl_vld` is 0. Both stored error samples are cleared to 0.
- R2: For each strobe, the new output is the previous output plus w0·e(n) + w1·e(n-1) + w2·e(n-2). All operands are two's-complement signed. e(n) is `err_in` at the strobe edge, and each weight is taken as a signed integer: Q4.8 with the output in the same 8-fraction-bit scale.
- R3: The error history advances only on a strobe edge. e(n-2) receives the old e(n-1), and e(n-1) receives `err_in`. Values on `err_in` without a strobe are ignored.
- R4: `ctl_out` updates, and `ctl_vld` is high, exactly on the second rising edge counted from the edge that sampled the strobe. `ctl_vld` is 0 in every other cycle.
- R5: `ctl_out` holds its value in every cycle in which `ctl_vld` is 0.
- R6: A sum above 8388607 (0x7FFFFF) produces 0x7FFFFF. The output never wraps negative.
- R7: A sum below -8388608 (0x800000) produces 0x800000. The output never wraps positive.
- R8: The weights are sampled only on the strobe edge. Changing them between strobes does not alter `ctl_out`.
- R9: Strobes on consecutive clock edges each produce their own update, with `ctl_vld` high on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | New error sample strobe |
| err_in | input | 12 | Signed error sample |
| w0 | input | 12 | Signed Q4.8 weight on e(n) |
| w1 | input | 12 | Signed Q4.8 weight on e(n-1) |
| w2 | input | 12 | Signed Q4.8 weight on e(n-2) |
| ctl_out | output | 24 | Signed saturated control value (8 fraction bits) |
| ctl_vld | output | 1 | One-cycle pulse on each output update |

## Verification
The assertions assume that `smp_stb` is a known level on every edge after reset. They also assume that `err_in` and the weights are known whenever a strobe is sampled, because the product and monotonic-clipping checks reason from those values. The no-wrap checks further assume the weights are static while a strobe is pending. The bench drives every input from a known value on the falling clock edge and changes weights and error values only between strobes. It includes one burst of two strobes on consecutive edges.

// File: rtl/zpid_pkg.sv
package zpid_pkg;
  // Number of error taps in the recursive form: e(n), e(n-1), e(n-2).
  localparam int unsigned NUM_TAPS = 3;
endpackage

// File: rtl/zpid_history.sv
module zpid_history #(
  parameter int unsigned ERR_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_stb,
  input  logic signed [ERR_W-1:0] err_in,
  output logic signed [ERR_W-1:0] err_d1,
  output logic signed [ERR_W-1:0] err_d2
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err_d1 <= '0;
      err_d2 <= '0;
    end else if (smp_stb) begin
      err_d2 <= err_d1;
      err_d1 <= err_in;
    end
  end

  // R3: history frozen without a strobe
  a_r3_hist_hold: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> ($stable(err_d1) && $stable(err_d2)));
  // R3: history shifts on a strobe
  a_r3_hist_shift: assert property (@(posedge clk) disable iff (rst)
    smp_stb |=> (err_d1 == $past(err_in) && err_d2 == $past(err_d1)));
endmodule

// File: rtl/zpid_taps.sv
module zpid_taps
  import zpid_pkg::*;
#(
  parameter int unsigned ERR_W  = 12,
  parameter int unsigned COEF_W = 12,
  localparam int unsigned PROD_W = ERR_W + COEF_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         smp_stb,
  input  logic [NUM_TAPS*ERR_W-1:0]    err_vec,
  input  logic [NUM_TAPS*COEF_W-1:0]   coef_vec,
  output logic [NUM_TAPS*PROD_W-1:0]   prod_vec,
  output logic                         prod_vld
);
  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    logic signed [ERR_W-1:0]  e_s;
    logic signed [COEF_W-1:0] c_s;
    logic signed [PROD_W-1:0] p_q;
    assign e_s = err_vec[t*ERR_W +: ERR_W];
    assign c_s = coef_vec[t*COEF_W +: COEF_W];
    always_ff @(posedge clk) begin
      if (rst)          p_q <= '0;
      else if (smp_stb) p_q <= e_s * c_s;
    end
    assign prod_vec[t*PROD_W +: PROD_W] = p_q;
  end

  always_ff @(posedge clk) begin
    if (rst) prod_vld <= 1'b0;
    else     prod_vld <= smp_stb;
  end
endmodule

// File: rtl/zpid_accum.sv
module zpid_accum
  import zpid_pkg::*;
#(
  parameter int unsigned PROD_W = 24,
  parameter int unsigned OUT_W  = 24,
  localparam int unsigned ACC_W = OUT_W + 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        prod_vld,
  input  logic [NUM_TAPS*PROD_W-1:0]  prod_vec,
  output logic signed [OUT_W-1:0]     y_q,
  output logic                        y_vld
);
  localparam logic signed [ACC_W-1:0] SAT_HI =
    {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO =
    {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc;
  logic signed [OUT_W-1:0] y_next;
  logic                    all_pos;
  logic                    all_neg;

  always_comb begin
    acc     = ACC_W'(y_q);
    all_pos = 1'b1;
    all_neg = 1'b1;
    for (int t = 0; t < NUM_TAPS; t++) begin
      acc = acc + ACC_W'($signed(prod_vec[t*PROD_W +: PROD_W]));
      if (prod_vec[t*PROD_W+PROD_W-1]) all_pos = 1'b0;
      else                             all_neg = 1'b0;
    end
    if (acc > SAT_HI)      y_next = SAT_HI[OUT_W-1:0];
    else if (acc < SAT_LO) y_next = SAT_LO[OUT_W-1:0];
    else                   y_next = acc[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q   <= '0;
      y_vld <= 1'b0;
    end else begin
      y_vld <= prod_vld;
      if (prod_vld) y_q <= y_next;
    end
  end

  // R5: output held between updates
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !y_vld |-> $stable(y_q));
  // R6: non-negative increments never lower the output (no wrap)
  a_r6_no_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (prod_vld && all_pos) |=> (y_q >= $past(y_q)));
  // R7: negative increments never raise the output (no wrap)
  a_r7_no_wrap_down: assert property (@(posedge clk) disable iff (rst)
    (prod_vld && all_neg) |=> (y_q <= $past(y_q)));
endmodule

// File: rtl/zpid_filter.sv
module zpid_filter
  import zpid_pkg::*;
#(
  parameter int unsigned ERR_W  = 12,
  parameter int unsigned COEF_W = 12,
  parameter int unsigned OUT_W  = 24,
  localparam int unsigned PROD_W = ERR_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_stb,
  input  logic signed [ERR_W-1:0]  err_in,
  input  logic signed [COEF_W-1:0] w0,
  input  logic signed [COEF_W-1:0] w1,
  input  logic signed [COEF_W-1:0] w2,
  output logic signed [OUT_W-1:0]  ctl_out,
  output logic                     ctl_vld
);
  logic signed [ERR_W-1:0]         e_d1, e_d2;
  logic [NUM_TAPS*PROD_W-1:0]      prods;
  logic                            prods_vld;

  zpid_history #(.ERR_W(ERR_W)) u_hist (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .err_in(err_in),
    .err_d1(e_d1), .err_d2(e_d2)
  );

  zpid_taps #(.ERR_W(ERR_W), .COEF_W(COEF_W)) u_taps (
    .clk(clk), .rst(rst), .smp_stb(smp_stb),
    .err_vec({e_d2, e_d1, err_in}),
    .coef_vec({w2, w1, w0}),
    .prod_vec(prods), .prod_vld(prods_vld)
  );

  zpid_accum #(.PROD_W(PROD_W), .OUT_W(OUT_W)) u_acc (
    .clk(clk), .rst(rst), .prod_vld(prods_vld), .prod_vec(prods),
    .y_q(ctl_out), .y_vld(ctl_vld)
  );

  // R1: reset clears output and history
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (ctl_out == '0 && !ctl_vld && e_d1 == '0 && e_d2 == '0));
  // R4: strobe answered by a valid pulse two edges later
  a_r4_valid_after_stb: assert property (@(posedge clk) disable iff (rst)
    smp_stb |=> ##1 ctl_vld);
  // R4: no valid pulse without a strobe two edges earlier
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> ##1 !ctl_vld);
endmodule

// File: tb/test_zpid_filter.sv
module test_zpid_filter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_stb = 1'b0;
  logic signed [11:0] err_in = '0;
  logic signed [11:0] w0 = '0, w1 = '0, w2 = '0;
  logic signed [23:0] ctl_out;
  logic ctl_vld;

  int total = 0;
  int bad   = 0;
  longint m_y = 0, m_e1 = 0, m_e2 = 0;

  always #5 clk = ~clk;

  zpid_filter i_zpid_filter (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .err_in(err_in),
    .w0(w0), .w1(w1), .w2(w2), .ctl_out(ctl_out), .ctl_vld(ctl_vld)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input longint e, input longint a0,
                                input longint a1, input longint a2);
    longint s;
    s = m_y + a0 * e + a1 * m_e1 + a2 * m_e2;
    if (s > 8388607) s = 8388607;
    if (s < -8388608) s = -8388608;
    m_y  = s;
    m_e2 = m_e1;
    m_e1 = e;
  endfunction

  // one strobed sample, checks timing and value
  task automatic sample(input int e, input int a0, input int a1, input int a2,
                        input string req);
    w0 = 12'(a0); w1 = 12'(a1); w2 = 12'(a2); err_in = 12'(e);
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    check({req, " R4 no early valid"}, longint'(ctl_vld), 0);
    @(negedge clk);
    model(e, a0, a1, a2);
    check({req, " R4 valid"}, longint'(ctl_vld), 1);
    check({req, " value"}, longint'(ctl_out), m_y);
    @(negedge clk);
    check({req, " R4 valid one cycle"}, longint'(ctl_vld), 0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_y = 0; m_e1 = 0; m_e2 = 0;
    check("R1 out zero", longint'(ctl_out), 0);
    check("R1 valid low", longint'(ctl_vld), 0);
  endtask

  task automatic t_equation;
    sample(100, 256, -300, 50, "R2 step1");
    sample(-37, 256, -300, 50, "R2 step2");
    sample(2047, -17, 400, -2048, "R2 step3");
    sample(-2048, 1000, 2047, 3, "R2 step4");
    sample(0, 5, 5, 5, "R2 step5");
  endtask

  task automatic t_ignore;
    // inputs toggled without strobe: history must not move
    for (int k = 0; k < 4; k++) begin
      err_in = 12'(700 + k * 11);
      @(negedge clk);
      check("R5 held", longint'(ctl_out), m_y);
      check("R3 no valid", longint'(ctl_vld), 0);
    end
    // weights only on e(n-1), e(n-2): exposes history
    sample(0, 0, 1, 0, "R3 d1 kept");
    sample(0, 0, 0, 1, "R3 d2 kept");
  endtask

  task automatic t_coef_change;
    sample(10, 3, 0, 0, "R8 base");
    w0 = 12'sd2047; w1 = -12'sd2048; w2 = 12'sd999;
    repeat (3) @(negedge clk);
    check("R8 unaffected", longint'(ctl_out), m_y);
  endtask

  task automatic t_back_to_back;
    w0 = 12'sd256; w1 = 12'sd0; w2 = 12'sd0;
    err_in = 12'sd20; smp_stb = 1'b1;
    @(negedge clk);
    err_in = -12'sd7;
    @(negedge clk);
    smp_stb = 1'b0;
    model(20, 256, 0, 0);
    check("R9 first valid", longint'(ctl_vld), 1);
    check("R9 first value", longint'(ctl_out), m_y);
    @(negedge clk);
    model(-7, 256, 0, 0);
    check("R9 second valid", longint'(ctl_vld), 1);
    check("R9 second value", longint'(ctl_out), m_y);
    @(negedge clk);
    check("R9 valid ends", longint'(ctl_vld), 0);
  endtask

  task automatic t_sat_pos;
    for (int k = 0; k < 4; k++) sample(2047, 2047, 0, 0, "R6 climb");
    check("R6 clipped high", longint'(ctl_out), 8388607);
  endtask

  task automatic t_sat_neg;
    for (int k = 0; k < 7; k++) sample(2047, -2048, 0, 0, "R7 fall");
    check("R7 clipped low", longint'(ctl_out), -8388608);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_equation();
    t_ignore();
    t_coef_change();
    t_back_to_back();
    t_sat_pos();
    t_sat_neg();
    t_reset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule